// File: doc/BRIEF.md
# I2C Interrupt Flag and Request Controller

This block holds the thirteen event and error flags of an I2C peripheral and turns them into interrupt requests. The protocol engine reports each event as a one-cycle set pulse on `set_i`. Each flag then stays set until the bus-side action that belongs to it arrives. That action is one of the following: a read of the receive data register, a write of the transmit data register, a control register write (with a byte-count field and start/stop request bits), or a write-one-to-clear access to the flag-clear register. The flag-clear register has no storage, so a read of it returns zero.

Seven enable bits gate the flags. Most event flags have an enable of their own. The two transfer-complete flags share one enable, and all six error flags share one error enable. A build-time parameter `SPLIT` selects how the gated requests leave the block. With `SPLIT`=0 they are ORed onto one line, `irq_all_o`. With `SPLIT`=1 they go out on an event line and an error line. All outputs are level-sensitive and registered. There is no streaming data path, so every pin is a plain control or status signal with no handshake.

Flag positions in `set_i`, `clr_bits_i` and `status_o` are as follows:
- bit 0: receive data present
- bit 1: transmit data wanted
- bit 2: stop seen
- bit 3: own address hit
- bit 4: NACK seen
- bit 5: byte-count reload due
- bit 6: transfer done
- bit 7: bus error
- bit 8: arbitration lost
- bit 9: overrun/underrun
- bit 10: packet check error
- bit 11: timeout
- bit 12: alert

Enable positions in `enable_i` are as follows:
- bit 0: receive
- bit 1: transmit
- bit 2: stop
- bit 3: address
- bit 4: NACK
- bit 5: transfer (covers flags 5 and 6)
- bit 6: error (covers flags 7 to 12)

Top module: `i2c_irq_ctrl`

## Requirements
- R1: Flag bit 0 sets on `set_i[0]` and is cleared only by a `rd_data_i` strobe. Data writes, control writes and clear-register writes leave it set.
- R2: Flag bit 1 sets on `set_i[1]` and is cleared only by a `wr_data_i` strobe. A data read or a control write leaves it set.
- R3: When `clr_wr_i` is high, a 1 in `clr_bits_i` clears flag bits 2, 3, 4 and 7 to 12. A 0 bit has no effect. Bits 0, 1, 5 and 6 of `clr_bits_i` are ignored.
- R4: Flag bit 5 is cleared by `ctrl_wr_i` with a nonzero `ctrl_count_i`. A control write with a count of zero leaves it unchanged.
- R5: Flag bit 6 is cleared by `ctrl_wr_i` with `ctrl_start_i` or `ctrl_stop_i` at 1. A control write with both bits at 0 leaves it set, whatever the count.
- R6: When a set pulse and a clear action reach the same flag in the same cycle, the flag ends up set.
- R7: A flag that is set and enabled drives its request line high one cycle after the flag is seen in `status_o`. The line stays high for as long as that condition holds and falls one cycle after the condition ends.
- R8: `enable_i[5]` alone gates flags 5 and 6. `enable_i[6]` alone gates flags 7 to 12. Any other enable bit has no effect on these flags.
- R9: With `SPLIT`=0, all requests appear on `irq_all_o`, and `irq_evt_o`/`irq_err_o` stay 0. With `SPLIT`=1, flags 0 to 6 drive `irq_evt_o`, flags 7 to 12 drive `irq_err_o`, and `irq_all_o` stays 0.
- R10: While `rst_n` is low, all flags and all request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | 13 | One-cycle set pulses from the protocol engine, one per flag |
| rd_data_i | input | 1 | Receive data register read strobe |
| wr_data_i | input | 1 | Transmit data register write strobe |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_count_i | input | CNT_W | Byte-count field of the control write |
| ctrl_start_i | input | 1 | Start request bit of the control write |
| ctrl_stop_i | input | 1 | Stop request bit of the control write |
| clr_wr_i | input | 1 | Flag-clear register write strobe |
| clr_bits_i | input | 13 | Write-one-to-clear data, aligned with the flag positions |
| enable_i | input | 7 | Interrupt enables |
| status_o | output | 13 | Current flag states |
| irq_all_o | output | 1 | Combined request (SPLIT=0) |
| irq_evt_o | output | 1 | Event request (SPLIT=1) |
| irq_err_o | output | 1 | Error request (SPLIT=1) |

## Verification
The case hardest to reach from the ports is a set pulse that lands in the same cycle as the clear action for the same flag. The protocol engine and software act independently, so this overlap only happens by coincidence. The stimulus forces it directly: it pulses `set_i` together with a data read on the receive flag, and together with a one-to-clear write on an error flag. A long random phase then produces many more overlaps. Two instances, one built per `SPLIT` value, receive the same inputs, so both ways of routing the requests are compared against one reference model in every cycle.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_FLAGS = 13;
  localparam int NUM_EN    = 7;

  // flag positions
  localparam int F_RXD   = 0;
  localparam int F_TXD   = 1;
  localparam int F_STOP  = 2;
  localparam int F_ADDR  = 3;
  localparam int F_NACK  = 4;
  localparam int F_RELD  = 5;
  localparam int F_DONE  = 6;
  localparam int F_ERR_LO = 7;

  // enable positions
  localparam int E_XFER = 5;
  localparam int E_ERR  = 6;

  // flags cleared through the write-one-to-clear register
  localparam logic [NUM_FLAGS-1:0] W1C_MASK = 13'h1F9C;
  localparam logic [NUM_FLAGS-1:0] ERR_MASK = 13'h1F80;
  localparam logic [NUM_FLAGS-1:0] EVT_MASK = ~ERR_MASK;

  // which enable bit gates a given flag
  function automatic int en_slot(input int flag);
    if (flag <= F_NACK)      return flag;
    else if (flag <= F_DONE) return E_XFER;
    else                     return E_ERR;
  endfunction
endpackage

// File: rtl/i2c_irq_clear_dec.sv
module i2c_irq_clear_dec
  import i2c_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 rd_data_i,
  input  logic                 wr_data_i,
  input  logic                 ctrl_wr_i,
  input  logic [CNT_W-1:0]     ctrl_count_i,
  input  logic                 ctrl_start_i,
  input  logic                 ctrl_stop_i,
  input  logic                 clr_wr_i,
  input  logic [NUM_FLAGS-1:0] clr_bits_i,
  output logic [NUM_FLAGS-1:0] clr_o
);
  logic [NUM_FLAGS-1:0] w1c_hit;
  logic [NUM_FLAGS-1:0] side_hit;

  assign w1c_hit = {NUM_FLAGS{clr_wr_i}} & clr_bits_i & W1C_MASK;

  always_comb begin
    side_hit         = '0;
    side_hit[F_RXD]  = rd_data_i;
    side_hit[F_TXD]  = wr_data_i;
    side_hit[F_RELD] = ctrl_wr_i && (ctrl_count_i != '0);
    side_hit[F_DONE] = ctrl_wr_i && (ctrl_start_i || ctrl_stop_i);
  end

  assign clr_o = w1c_hit | side_hit;
endmodule

// File: rtl/i2c_irq_flag_bank.sv
module i2c_irq_flag_bank
  import i2c_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flag_o
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;   // set has priority
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/i2c_irq_route.sv
module i2c_irq_route
  import i2c_irq_pkg::*;
#(
  parameter bit SPLIT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] flag_i,
  input  logic [NUM_EN-1:0]    enable_i,
  output logic                 irq_all_o,
  output logic                 irq_evt_o,
  output logic                 irq_err_o
);
  logic [NUM_FLAGS-1:0] en_mask;
  logic [NUM_FLAGS-1:0] live;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_mask
    assign en_mask[i] = enable_i[en_slot(i)];
  end

  assign live = flag_i & en_mask;

  if (SPLIT) begin : g_split
    logic evt_q, err_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evt_q <= 1'b0;
        err_q <= 1'b0;
      end else begin
        evt_q <= |(live & EVT_MASK);
        err_q <= |(live & ERR_MASK);
      end
    end
    assign irq_evt_o = evt_q;
    assign irq_err_o = err_q;
    assign irq_all_o = 1'b0;
  end else begin : g_merged
    logic all_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) all_q <= 1'b0;
      else        all_q <= |live;
    end
    assign irq_all_o = all_q;
    assign irq_evt_o = 1'b0;
    assign irq_err_o = 1'b0;
  end
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter bit SPLIT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic                 rd_data_i,
  input  logic                 wr_data_i,
  input  logic                 ctrl_wr_i,
  input  logic [CNT_W-1:0]     ctrl_count_i,
  input  logic                 ctrl_start_i,
  input  logic                 ctrl_stop_i,
  input  logic                 clr_wr_i,
  input  logic [NUM_FLAGS-1:0] clr_bits_i,
  input  logic [NUM_EN-1:0]    enable_i,
  output logic [NUM_FLAGS-1:0] status_o,
  output logic                 irq_all_o,
  output logic                 irq_evt_o,
  output logic                 irq_err_o
);
  logic [NUM_FLAGS-1:0] clr;
  logic [NUM_FLAGS-1:0] flags;

  i2c_irq_clear_dec #(.CNT_W(CNT_W)) u_dec (
    .rd_data_i    (rd_data_i),
    .wr_data_i    (wr_data_i),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_count_i (ctrl_count_i),
    .ctrl_start_i (ctrl_start_i),
    .ctrl_stop_i  (ctrl_stop_i),
    .clr_wr_i     (clr_wr_i),
    .clr_bits_i   (clr_bits_i),
    .clr_o        (clr)
  );

  i2c_irq_flag_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_i),
    .clr_i  (clr),
    .flag_o (flags)
  );

  i2c_irq_route #(.SPLIT(SPLIT)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_i    (flags),
    .enable_i  (enable_i),
    .irq_all_o (irq_all_o),
    .irq_evt_o (irq_evt_o),
    .irq_err_o (irq_err_o)
  );

  assign status_o = flags;
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk
  import i2c_irq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter bit SPLIT = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_FLAGS-1:0] set_i,
  input logic                 rd_data_i,
  input logic                 ctrl_wr_i,
  input logic [CNT_W-1:0]     ctrl_count_i,
  input logic                 ctrl_start_i,
  input logic                 ctrl_stop_i,
  input logic                 clr_wr_i,
  input logic                 clr_nack_i,
  input logic [NUM_EN-1:0]    enable_i,
  input logic [NUM_FLAGS-1:0] status_o,
  input logic                 irq_all_o,
  input logic                 irq_evt_o,
  input logic                 irq_err_o
);
  // R1: receive flag holds until a data read
  p_rx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[F_RXD] && !rd_data_i) |=> status_o[F_RXD]);

  // R3: NACK flag holds unless its clear bit is written as 1
  p_w1c_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[F_NACK] && !(clr_wr_i && clr_nack_i)) |=> status_o[F_NACK]);

  // R4: reload flag survives anything but a nonzero count write
  p_reload_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[F_RELD] && !(ctrl_wr_i && (ctrl_count_i != '0))) |=> status_o[F_RELD]);

  // R5: start or stop request clears the done flag
  p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && (ctrl_start_i || ctrl_stop_i) && !set_i[F_DONE]) |=> !status_o[F_DONE]);

  // R6: every pulsed flag is set afterwards
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

  // R7: an enabled receive flag raises the event request
  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i[F_RXD] && status_o[F_RXD]) |=> (SPLIT ? irq_evt_o : irq_all_o));

  // R8: no enable, no request
  p_gated_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i == '0) |=> !(irq_all_o || irq_evt_o || irq_err_o));

  // R10: state leaving reset is clear
  p_reset_clear_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (status_o == '0 && !irq_all_o && !irq_evt_o && !irq_err_o));
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk #(.CNT_W(CNT_W), .SPLIT(SPLIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .set_i        (set_i),
  .rd_data_i    (rd_data_i),
  .ctrl_wr_i    (ctrl_wr_i),
  .ctrl_count_i (ctrl_count_i),
  .ctrl_start_i (ctrl_start_i),
  .ctrl_stop_i  (ctrl_stop_i),
  .clr_wr_i     (clr_wr_i),
  .clr_nack_i   (clr_bits_i[4]),
  .enable_i     (enable_i),
  .status_o     (status_o),
  .irq_all_o    (irq_all_o),
  .irq_evt_o    (irq_evt_o),
  .irq_err_o    (irq_err_o)
);

// File: tb/sim_i2c_irq_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_irq_ctrl;
  localparam int NF = 13;
  localparam int NE = 7;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NF-1:0] set_i = '0;
  logic rd_data_i = 0, wr_data_i = 0, ctrl_wr_i = 0;
  logic [CW-1:0] ctrl_count_i = '0;
  logic ctrl_start_i = 0, ctrl_stop_i = 0, clr_wr_i = 0;
  logic [NF-1:0] clr_bits_i = '0;
  logic [NE-1:0] enable_i = '0;

  logic [NF-1:0] st0, st1;
  logic all0, evt0, err0, all1, evt1, err1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  i2c_irq_ctrl #(.CNT_W(CW), .SPLIT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .rd_data_i(rd_data_i),
    .wr_data_i(wr_data_i), .ctrl_wr_i(ctrl_wr_i), .ctrl_count_i(ctrl_count_i),
    .ctrl_start_i(ctrl_start_i), .ctrl_stop_i(ctrl_stop_i), .clr_wr_i(clr_wr_i),
    .clr_bits_i(clr_bits_i), .enable_i(enable_i), .status_o(st0),
    .irq_all_o(all0), .irq_evt_o(evt0), .irq_err_o(err0));

  i2c_irq_ctrl #(.CNT_W(CW), .SPLIT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .rd_data_i(rd_data_i),
    .wr_data_i(wr_data_i), .ctrl_wr_i(ctrl_wr_i), .ctrl_count_i(ctrl_count_i),
    .ctrl_start_i(ctrl_start_i), .ctrl_stop_i(ctrl_stop_i), .clr_wr_i(clr_wr_i),
    .clr_bits_i(clr_bits_i), .enable_i(enable_i), .status_o(st1),
    .irq_all_o(all1), .irq_evt_o(evt1), .irq_err_o(err1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_flag [NF];
  bit m_all, m_evt, m_err;

  function automatic int gate_of(input int f);
    case (f)
      0, 1, 2, 3, 4: return f;
      5, 6:          return 5;
      default:       return 6;
    endcase
  endfunction

  function automatic bit clears(input int f);
    case (f)
      0: return rd_data_i;
      1: return wr_data_i;
      5: return ctrl_wr_i && (ctrl_count_i != 0);
      6: return ctrl_wr_i && (ctrl_start_i || ctrl_stop_i);
      default: return clr_wr_i && clr_bits_i[f];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_flag[f]) m_flag[f] = 0;
      m_all = 0; m_evt = 0; m_err = 0;
    end else begin
      bit a, e, r;
      a = 0; e = 0; r = 0;
      foreach (m_flag[f]) begin
        if (m_flag[f] && enable_i[gate_of(f)]) begin
          a = 1;
          if (f < 7) e = 1; else r = 1;
        end
      end
      m_all = a; m_evt = e; m_err = r;
      foreach (m_flag[f]) begin
        if (set_i[f])       m_flag[f] = 1;
        else if (clears(f)) m_flag[f] = 0;
      end
    end
  end

  function automatic logic [NF-1:0] model_status();
    logic [NF-1:0] v;
    foreach (m_flag[f]) v[f] = m_flag[f];
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 model status", {19'd0, st0}, {19'd0, model_status()});
      check("R9 model split status", {19'd0, st1}, {19'd0, model_status()});
      check("R7 model merged irq", {29'd0, all0, evt0, err0}, {29'd0, m_all, 2'b00});
      check("R9 model split irq", {29'd0, all1, evt1, err1}, {29'd0, 1'b0, m_evt, m_err});
    end
  end

  // ---------------- directed and random stimulus ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    set_i = '0; rd_data_i = 0; wr_data_i = 0; ctrl_wr_i = 0; ctrl_count_i = '0;
    ctrl_start_i = 0; ctrl_stop_i = 0; clr_wr_i = 0; clr_bits_i = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) tick();
    check("R10 reset status", {19'd0, st0}, 32'd0);
    check("R10 reset irq", {28'd0, all0, all1, evt1, err1}, 32'd0);
    rst_n = 1'b1;
    enable_i = 7'h7F;

    // R1 receive flag
    set_i = 13'h0001; tick(); quiet();
    check("R1 rx set", {19'd0, st0}, 32'h1);
    tick();
    check("R7 merged irq up", {31'd0, all0}, 32'd1);
    check("R9 split evt up", {30'd0, evt1, err1}, 32'h2);
    wr_data_i = 1; clr_wr_i = 1; clr_bits_i = 13'h1FFF; tick(); quiet();
    check("R1 rx kept by write/clear", {19'd0, st0}, 32'h1);
    rd_data_i = 1; tick(); quiet();
    check("R1 rx cleared by read", {19'd0, st0}, 32'h0);
    tick();
    check("R7 irq falls", {31'd0, all0}, 32'd0);

    // R2 transmit flag
    set_i = 13'h0002; tick(); quiet();
    rd_data_i = 1; ctrl_wr_i = 1; ctrl_count_i = 8'd1; ctrl_start_i = 1; tick(); quiet();
    check("R2 tx kept", {19'd0, st0}, 32'h2);
    wr_data_i = 1; tick(); quiet();
    check("R2 tx cleared by write", {19'd0, st0}, 32'h0);

    // R3 write-one-to-clear
    set_i = 13'h1F9C; tick(); quiet();
    check("R3 w1c set", {19'd0, st0}, 32'h1F9C);
    clr_wr_i = 1; clr_bits_i = 13'h0000; tick(); quiet();
    check("R3 zero write no effect", {19'd0, st0}, 32'h1F9C);
    clr_wr_i = 1; clr_bits_i = 13'h0008; tick(); quiet();
    check("R3 single clear", {19'd0, st0}, 32'h1F94);
    clr_wr_i = 1; clr_bits_i = 13'h1FFF; tick(); quiet();
    check("R3 all cleared", {19'd0, st0}, 32'h0);

    // R4 reload flag
    set_i = 13'h0020; tick(); quiet();
    ctrl_wr_i = 1; ctrl_count_i = 8'd0; tick(); quiet();
    check("R4 zero count keeps", {19'd0, st0}, 32'h20);
    ctrl_wr_i = 1; ctrl_count_i = 8'd3; tick(); quiet();
    check("R4 nonzero count clears", {19'd0, st0}, 32'h0);

    // R5 transfer done flag
    set_i = 13'h0040; tick(); quiet();
    ctrl_wr_i = 1; ctrl_count_i = 8'd5; tick(); quiet();
    check("R5 no start/stop keeps", {19'd0, st0}, 32'h40);
    ctrl_wr_i = 1; ctrl_start_i = 1; tick(); quiet();
    check("R5 start clears", {19'd0, st0}, 32'h0);
    set_i = 13'h0040; tick(); quiet();
    ctrl_wr_i = 1; ctrl_stop_i = 1; tick(); quiet();
    check("R5 stop clears", {19'd0, st0}, 32'h0);

    // R6 set beats clear
    set_i = 13'h0001; tick(); quiet();
    set_i = 13'h0001; rd_data_i = 1; tick(); quiet();
    check("R6 rx set wins", {19'd0, st0}, 32'h1);
    set_i = 13'h0100; clr_wr_i = 1; clr_bits_i = 13'h0100; tick(); quiet();
    check("R6 w1c set wins", {19'd0, st0}, 32'h101);
    rd_data_i = 1; clr_wr_i = 1; clr_bits_i = 13'h0100; tick(); quiet();
    check("R6 later clear", {19'd0, st0}, 32'h0);

    // R8 enable grouping
    enable_i = 7'h00;
    set_i = 13'h0200; tick(); quiet(); tick();
    check("R8 disabled error no irq", {31'd0, all0}, 32'd0);
    enable_i = 7'h40; tick();
    check("R8 error enable", {31'd0, all0}, 32'd1);
    check("R9 error line", {30'd0, evt1, err1}, 32'h1);
    enable_i = 7'h3F; tick();
    check("R8 other enables ignored", {31'd0, all0}, 32'd0);
    clr_wr_i = 1; clr_bits_i = 13'h0200; set_i = 13'h0040; enable_i = 7'h20; tick(); quiet();
    tick();
    check("R8 xfer enable covers done", {31'd0, all0}, 32'd1);
    check("R9 event line", {30'd0, evt1, err1}, 32'h2);
    repeat (5) tick();
    check("R7 level held", {31'd0, all0}, 32'd1);
    ctrl_wr_i = 1; ctrl_stop_i = 1; tick(); quiet(); tick();
    check("R7 level drops", {31'd0, all0}, 32'd0);

    // random phase, checked by the model every cycle
    for (int n = 0; n < 4000; n++) begin
      set_i = NF'($urandom & $urandom & $urandom);
      rd_data_i = ($urandom_range(0, 3) == 0);
      wr_data_i = ($urandom_range(0, 3) == 0);
      ctrl_wr_i = ($urandom_range(0, 3) == 0);
      ctrl_count_i = ($urandom_range(0, 1) == 0) ? 8'd0 : CW'($urandom);
      ctrl_start_i = ($urandom_range(0, 3) == 0);
      ctrl_stop_i = ($urandom_range(0, 3) == 0);
      clr_wr_i = ($urandom_range(0, 2) == 0);
      clr_bits_i = NF'($urandom);
      if ($urandom_range(0, 15) == 0) enable_i = NE'($urandom);
      tick();
    end
    quiet();
    tick();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule